// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache that sits between an address generator and the page-table walker. Each entry carries a valid bit, an address-space tag, a virtual page number, a physical frame number and a pin flag. On a lookup, every entry is compared at once against the requested page and the current address-space tag. A hit returns the physical address, which is the stored frame placed above the unchanged page offset. A miss raises a request for a refill, which holds until the walker delivers a translation. The refill is then written into a free entry, or else into the least recently used entry that is not pinned.

The address-space tag lets translations from several processes share the buffer, so a context switch needs no flush. Pinned entries keep permanent translations resident. Software can drop every unpinned entry, or only the unpinned entries of one address space. A refill whose page and tag are already present overwrites that entry in place. If every entry is pinned and no entry matches, the refill is discarded and a one-cycle drop flag is raised.

A two-state controller tracks refills. `ST_READY` is the normal state. It moves to `ST_AWAIT_FILL` on the transition *miss* (a lookup with no matching entry). `ST_AWAIT_FILL` returns to `ST_READY` on the transition *fill_taken* (a refill is accepted, whether it is written or dropped). Lookups are served in both states. The entry count must be a power of two.

Top module: `tlb_asid`

## Requirements
- R1: After reset all entries are invalid and unpinned, and `rsp_valid`, `rsp_hit`, `fill_req` and `fill_drop` are 0.
- R2: A lookup sampled at a rising edge gives `rsp_valid`=1 for exactly the following cycle. `rsp_hit` is 1 when a valid entry matches both the page and `cur_asid`, and `rsp_paddr` is then {frame, offset} with the frame in the upper FRAME_W bits. On a miss `rsp_paddr` is 0.
- R3: An entry whose stored address-space tag differs from `cur_asid` never produces a hit, even when its page matches.
- R4: A missing lookup moves the controller to `ST_AWAIT_FILL`. `fill_req` is 1 from the cycle of the miss response until the edge at which a refill is accepted. Lookups are still answered while the refill is awaited.
- R5: An accepted refill makes later lookups of that page and tag hit with the new frame. A refill whose page and tag already exist overwrites that entry, so no duplicate is created.
- R6: A new refill goes to the lowest-numbered invalid entry if one exists. Otherwise it goes to the least recently used unpinned entry. Both hits and refills count as uses.
- R7: A pinned entry is never evicted by a refill, and no flush clears it.
- R8: If no entry matches and every entry is pinned, the refill is discarded and `fill_drop` is 1 for the one following cycle.
- R9: `flush_all` invalidates every unpinned entry.
- R10: `flush_asid_en` invalidates only the unpinned entries whose tag equals `flush_asid`.
- R11: One operation is taken per cycle, in this priority: `flush_all`, then `flush_asid_en`, then `fill_valid`, then `lk_valid`. A lower-priority request in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_page | input | PAGE_W | Virtual page number to translate |
| lk_offset | input | OFF_W | Page offset, passed through |
| cur_asid | input | ASID_W | Address space of the running process |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address on hit |
| fill_req | output | 1 | A refill is awaited |
| fill_valid | input | 1 | Refill write request |
| fill_asid | input | ASID_W | Address-space tag of the refill |
| fill_page | input | PAGE_W | Page of the refill |
| fill_frame | input | FRAME_W | Frame of the refill |
| fill_wired | input | 1 | Pin the refilled entry |
| fill_drop | output | 1 | Refill discarded, all entries pinned |
| flush_all | input | 1 | Invalidate all unpinned entries |
| flush_asid_en | input | 1 | Invalidate unpinned entries of one tag |
| flush_asid | input | ASID_W | Tag selected by the per-tag flush |

## Verification
The bench builds the buffer with 8 entries, 6-bit pages, 4-bit offsets, 8-bit frames and 3-bit tags. With this size, every offset of every resident page can be swept, and the buffer can be filled to capacity with only a few refills. LRU eviction order, full pinning with the drop path, and tag-selective flushing can then be driven to their edges in a few hundred cycles. Each frame is computed in the bench from the page and the tag, so every physical address can be predicted arithmetically.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
    typedef enum logic [0:0] {ST_READY, ST_AWAIT_FILL} tlb_state_e;
    typedef enum logic [2:0] {OP_NONE, OP_FLUSH_ALL, OP_FLUSH_ASID, OP_FILL, OP_LOOKUP} tlb_op_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N      = 64,
    parameter int ASID_W = 8,
    parameter int PAGE_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [N-1:0][PAGE_W-1:0] ent_page,
    input  logic [ASID_W-1:0]        key_asid,
    input  logic [PAGE_W-1:0]        key_page,
    output logic                     hit_any,
    output logic [IDX_W-1:0]         hit_idx
);
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_page[g] == key_page) && (ent_asid[g] == key_asid);
    end

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i] && !hit_any) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [N-1:0]     ent_valid,
    input  logic [N-1:0]     ent_wired,
    output logic             victim_ok,
    output logic [IDX_W-1:0] victim_idx
);
    logic [N-1:0][IDX_W-1:0] age;
    logic [IDX_W-1:0]        old_age;
    logic                    have_inv;
    logic [IDX_W-1:0]        inv_idx;
    logic [IDX_W-1:0]        best_idx;
    logic [IDX_W-1:0]        best_age;

    assign old_age = age[touch_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx) age[i] <= '0;
                else if (age[i] < old_age) age[i] <= age[i] + 1'b1;
            end
        end
    end

    always_comb begin
        have_inv  = 1'b0;
        inv_idx   = '0;
        victim_ok = 1'b0;
        best_idx  = '0;
        best_age  = '0;
        for (int i = 0; i < N; i++) begin
            if (!ent_wired[i] && !ent_valid[i] && !have_inv) begin
                have_inv = 1'b1;
                inv_idx  = IDX_W'(i);
            end
            if (!ent_wired[i] && (!victim_ok || age[i] > best_age)) begin
                victim_ok = 1'b1;
                best_idx  = IDX_W'(i);
                best_age  = age[i];
            end
        end
        victim_idx = have_inv ? inv_idx : best_idx;
    end
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
    import tlb_asid_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ASID_W  = 8,
    parameter int PAGE_W  = 20,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [PAGE_W-1:0]        lk_page,
    input  logic [OFF_W-1:0]         lk_offset,
    input  logic [ASID_W-1:0]        cur_asid,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
    output logic                     fill_req,
    input  logic                     fill_valid,
    input  logic [ASID_W-1:0]        fill_asid,
    input  logic [PAGE_W-1:0]        fill_page,
    input  logic [FRAME_W-1:0]       fill_frame,
    input  logic                     fill_wired,
    output logic                     fill_drop,
    input  logic                     flush_all,
    input  logic                     flush_asid_en,
    input  logic [ASID_W-1:0]        flush_asid
);
    logic [ENTRIES-1:0]              ent_valid;
    logic [ENTRIES-1:0]              ent_wired;
    logic [ENTRIES-1:0][ASID_W-1:0]  ent_asid;
    logic [ENTRIES-1:0][PAGE_W-1:0]  ent_page;
    logic [ENTRIES-1:0][FRAME_W-1:0] ent_frame;

    tlb_state_e       state, state_nx;
    tlb_op_e          op;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic             victim_ok;
    logic [IDX_W-1:0] victim_idx;
    logic             write_ok;
    logic [IDX_W-1:0] tgt_idx;
    logic             touch;
    logic [IDX_W-1:0] touch_idx;

    always_comb begin
        if (flush_all)          op = OP_FLUSH_ALL;
        else if (flush_asid_en) op = OP_FLUSH_ASID;
        else if (fill_valid)    op = OP_FILL;
        else if (lk_valid)      op = OP_LOOKUP;
        else                    op = OP_NONE;
    end

    tlb_cam #(.N(ENTRIES), .ASID_W(ASID_W), .PAGE_W(PAGE_W)) i_cam (
        .ent_valid (ent_valid),
        .ent_asid  (ent_asid),
        .ent_page  (ent_page),
        .key_asid  ((op == OP_FILL) ? fill_asid : cur_asid),
        .key_page  ((op == OP_FILL) ? fill_page : lk_page),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx)
    );

    assign write_ok  = hit_any || victim_ok;
    assign tgt_idx   = hit_any ? hit_idx : victim_idx;
    assign touch     = ((op == OP_LOOKUP) && hit_any) || ((op == OP_FILL) && write_ok);
    assign touch_idx = (op == OP_FILL) ? tgt_idx : hit_idx;

    tlb_lru #(.N(ENTRIES)) i_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .ent_valid  (ent_valid),
        .ent_wired  (ent_wired),
        .victim_ok  (victim_ok),
        .victim_idx (victim_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_wired <= '0;
            ent_asid  <= '0;
            ent_page  <= '0;
            ent_frame <= '0;
        end else begin
            unique case (op)
                OP_FLUSH_ALL:  ent_valid <= ent_valid & ent_wired;
                OP_FLUSH_ASID: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (!ent_wired[i] && ent_asid[i] == flush_asid) ent_valid[i] <= 1'b0;
                end
                OP_FILL: begin
                    if (write_ok) begin
                        ent_valid[tgt_idx] <= 1'b1;
                        ent_wired[tgt_idx] <= fill_wired;
                        ent_asid[tgt_idx]  <= fill_asid;
                        ent_page[tgt_idx]  <= fill_page;
                        ent_frame[tgt_idx] <= fill_frame;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            fill_drop <= 1'b0;
        end else begin
            rsp_valid <= (op == OP_LOOKUP);
            rsp_hit   <= (op == OP_LOOKUP) && hit_any;
            rsp_paddr <= ((op == OP_LOOKUP) && hit_any) ? {ent_frame[hit_idx], lk_offset} : '0;
            fill_drop <= (op == OP_FILL) && !write_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        fill_req = 1'b0;
        unique case (state)
            ST_READY: begin
                if (op == OP_LOOKUP && !hit_any) state_nx = ST_AWAIT_FILL;
            end
            ST_AWAIT_FILL: begin
                fill_req = 1'b1;
                if (op == OP_FILL) state_nx = ST_READY;
            end
            default: state_nx = ST_READY;
        endcase
    end
endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk (
    input logic clk,
    input logic rst_n,
    input logic lk_valid,
    input logic fill_valid,
    input logic flush_all,
    input logic flush_asid_en,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic fill_req,
    input logic fill_drop
);
    // R2
    rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid && !fill_valid && !flush_all && !flush_asid_en));

    // R2
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R4
    req_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> (rsp_valid && !rsp_hit));

    // R4
    req_clears_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid && !flush_all && !flush_asid_en) |=> !fill_req);

    // R8
    drop_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_drop |-> $past(fill_valid && !flush_all && !flush_asid_en));

    // R11
    flush_blocks_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (!rsp_valid && !fill_drop));
endmodule

bind tlb_asid tlb_asid_chk i_tlb_asid_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .fill_valid    (fill_valid),
    .flush_all     (flush_all),
    .flush_asid_en (flush_asid_en),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .fill_req      (fill_req),
    .fill_drop     (fill_drop)
);

// File: tb/test_tlb_asid.sv
`timescale 1ns/1ps
module test_tlb_asid;
    localparam int N = 8, AW = 3, PW = 6, OW = 4, FW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0, fill_valid = 0, fill_wired = 0, flush_all = 0, flush_asid_en = 0;
    logic [PW-1:0] lk_page = '0, fill_page = '0;
    logic [OW-1:0] lk_offset = '0;
    logic [AW-1:0] cur_asid = '0, fill_asid = '0, flush_asid = '0;
    logic [FW-1:0] fill_frame = '0;
    logic rsp_valid, rsp_hit, fill_req, fill_drop;
    logic [FW+OW-1:0] rsp_paddr;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    tlb_asid #(.ENTRIES(N), .ASID_W(AW), .PAGE_W(PW), .OFF_W(OW), .FRAME_W(FW)) i_tlb_asid (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_page(lk_page), .lk_offset(lk_offset),
        .cur_asid(cur_asid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .fill_req(fill_req), .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_page(fill_page),
        .fill_frame(fill_frame), .fill_wired(fill_wired), .fill_drop(fill_drop),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid));

    function automatic logic [FW-1:0] frm(input int page, input int asid);
        return FW'((page * 5 + asid * 29 + 3) & 8'hFF);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        lk_valid = 0; fill_valid = 0; flush_all = 0; flush_asid_en = 0; fill_wired = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle_all(); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic lookup(input int page, input int asid, input int off);
        @(negedge clk);
        lk_valid = 1; lk_page = PW'(page); cur_asid = AW'(asid); lk_offset = OW'(off);
        @(negedge clk);
        idle_all();
    endtask

    // expect hit (hit=1) with frame f, or miss (hit=0)
    task automatic expect_lk(input string req, input int page, input int asid, input int off,
                             input bit hit, input int f);
        lookup(page, asid, off);
        chk({req, " rsp_valid"}, rsp_valid, 1);
        chk({req, " hit"}, rsp_hit, hit);
        chk({req, " paddr"}, rsp_paddr, hit ? ((f << OW) | off) : 0);
    endtask

    task automatic fill(input int page, input int asid, input int f, input bit wired);
        @(negedge clk);
        fill_valid = 1; fill_page = PW'(page); fill_asid = AW'(asid);
        fill_frame = FW'(f); fill_wired = wired;
        @(negedge clk);
        idle_all();
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 fill_req", fill_req, 0);
        chk("R1 fill_drop", fill_drop, 0);
        expect_lk("R1 empty", 0, 0, 0, 0, 0);
        // R4: miss raises request, lookups served while waiting
        chk("R4 fill_req after miss", fill_req, 1);
        expect_lk("R4 lookup while awaiting", 3, 1, 2, 0, 0);
        chk("R4 fill_req held", fill_req, 1);
        fill(0, 1, frm(0, 1), 0);
        chk("R4 fill_req cleared", fill_req, 0);

        // R2 R5: fill all, exhaustive offset sweep
        do_reset();
        for (int p = 0; p < N; p++) fill(p, 1, frm(p, 1), 0);
        for (int p = 0; p < N; p++)
            for (int o = 0; o < (1 << OW); o++) expect_lk("R2 sweep", p, 1, o, 1, frm(p, 1));
        // R3: other tag misses
        for (int p = 0; p < N; p++) expect_lk("R3 other asid", p, 2, 0, 0, 0);
        fill(63, 2, 0, 0);

        // R6: LRU eviction order
        do_reset();
        for (int p = 0; p < N; p++) fill(p, 1, frm(p, 1), 0);
        for (int p = 1; p < N; p++) expect_lk("R6 touch", p, 1, 1, 1, frm(p, 1));
        fill(8, 1, frm(8, 1), 0);
        expect_lk("R6 lru evicted", 0, 1, 0, 0, 0);
        for (int p = 1; p <= 8; p++) expect_lk("R6 kept", p, 1, 0, 1, frm(p, 1));
        fill(9, 1, frm(9, 1), 0);
        expect_lk("R6 second lru evicted", 1, 1, 0, 0, 0);
        for (int p = 2; p <= 9; p++) expect_lk("R6 kept2", p, 1, 0, 1, frm(p, 1));

        // R7 R8 R9: pinning, full-pin drop
        do_reset();
        for (int p = 0; p < N - 1; p++) fill(p, 1, frm(p, 1), 1);
        fill(7, 1, frm(7, 1), 0);
        fill(10, 1, frm(10, 1), 0);
        expect_lk("R7 unpinned evicted", 7, 1, 0, 0, 0);
        expect_lk("R7 new present", 10, 1, 0, 1, frm(10, 1));
        for (int p = 0; p < N - 1; p++) expect_lk("R7 pinned kept", p, 1, 5, 1, frm(p, 1));
        @(negedge clk); flush_all = 1; @(negedge clk); idle_all();
        expect_lk("R9 unpinned flushed", 10, 1, 0, 0, 0);
        for (int p = 0; p < N - 1; p++) expect_lk("R9 pinned survive", p, 1, 0, 1, frm(p, 1));
        fill(11, 1, frm(11, 1), 1);
        chk("R8 no drop while room", fill_drop, 0);
        fill(12, 1, frm(12, 1), 0);
        chk("R8 drop flag", fill_drop, 1);
        @(negedge clk);
        chk("R8 drop one cycle", fill_drop, 0);
        expect_lk("R8 dropped absent", 12, 1, 0, 0, 0);
        fill(3, 1, frm(3, 1) ^ 8'hA5, 1);
        chk("R5 overwrite pinned no drop", fill_drop, 0);
        expect_lk("R5 overwrite value", 3, 1, 7, 1, frm(3, 1) ^ 8'hA5);
        @(negedge clk); flush_asid_en = 1; flush_asid = 1; @(negedge clk); idle_all();
        expect_lk("R7 pinned survive tag flush", 11, 1, 0, 1, frm(11, 1));

        // R10: flush by tag
        do_reset();
        for (int p = 0; p < 4; p++) begin
            fill(p, 1, frm(p, 1), 0);
            fill(p, 2, frm(p, 2), 0);
        end
        for (int p = 0; p < 4; p++) expect_lk("R3 tag select", p, 2, 3, 1, frm(p, 2));
        @(negedge clk); flush_asid_en = 1; flush_asid = 1; @(negedge clk); idle_all();
        for (int p = 0; p < 4; p++) begin
            expect_lk("R10 tag flushed", p, 1, 0, 0, 0);
            expect_lk("R10 other tag kept", p, 2, 0, 1, frm(p, 2));
        end

        // R5: no duplicate on refill of existing page
        do_reset();
        fill(5, 1, frm(5, 1) ^ 8'h3C, 0);
        fill(5, 1, frm(5, 1), 0);
        for (int p = 20; p < 27; p++) fill(p, 1, frm(p, 1), 0);
        expect_lk("R5 latest frame", 5, 1, 9, 1, frm(5, 1));
        for (int p = 20; p < 27; p++) expect_lk("R5 no duplicate", p, 1, 0, 1, frm(p, 1));

        // R11: priority
        do_reset();
        @(negedge clk);
        fill_valid = 1; fill_page = 1; fill_asid = 1; fill_frame = frm(1, 1); fill_wired = 1;
        lk_valid = 1; lk_page = 1; cur_asid = 1;
        @(negedge clk); idle_all();
        chk("R11 lookup ignored under fill", rsp_valid, 0);
        @(negedge clk);
        flush_all = 1; fill_valid = 1; fill_page = 2; fill_asid = 1; fill_frame = frm(2, 1);
        @(negedge clk); idle_all();
        expect_lk("R11 fill ignored under flush", 2, 1, 0, 0, 0);
        expect_lk("R11 earlier fill kept", 1, 1, 0, 1, frm(1, 1));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule